// File: doc/BRIEF.md
# Parallel Printer Port Receiver

This block is the printer end of a byte-wide parallel link that follows the Centronics-style convention. The host places a byte on eight data lines and pulses an active-low strobe. The receiver answers with an active-low acknowledge pulse and a busy line. A local consumer inside the printer asks for each byte with a one-cycle request. The receiver then lowers busy and sends an acknowledge pulse of a fixed length. After that it waits for the host's strobe. It latches the data on the strobe's falling edge, passes the byte to the consumer with a one-cycle valid, and raises busy again until the next request.

The strobe comes from another clock domain, so it passes through a synchronizer first. The data lines are delayed by the same number of stages, so the byte that is latched matches the strobe edge. The host may strobe while the receiver has not asked for data. Such strobes are dropped, and a saturating counter records them.

Top module: `lpt_receiver`

## Requirements
- R1: After reset, and whenever reset is applied mid-operation, busy is 1, ack_n is 1, rx_valid is 0, ovr_count is 0 and rx_data is 0, so no earlier byte survives.
- R2: A one-cycle req while idle (busy high) makes busy and ack_n both 0 from the next clock edge.
- R3: ack_n stays low for exactly ACK_CYCLES clock cycles, then returns to 1 while busy stays 0.
- R4: In the waiting phase (busy 0, ack_n 1), a falling edge on host_strobe_n latches host_data. That byte appears on rx_data with rx_valid high for exactly one cycle.
- R5: busy returns to 1 in the same cycle that rx_valid is high. It stays 1, with no further acknowledge pulse, until the next req.
- R6: A falling edge on host_strobe_n while busy is 1 produces no rx_valid and leaves rx_data unchanged. It raises ovr_count by one.
- R7: ovr_count saturates at 2^OVR_W-1 and never wraps.
- R8: A req that arrives while a transfer is under way has no effect. The acknowledge pulse keeps its length, and exactly one byte is delivered for the transfer.
- R9: A falling strobe edge during the acknowledge pulse is ignored and not counted as an overrun. Only a later edge in the waiting phase is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_data | input | DATA_W | Data lines from the host |
| host_strobe_n | input | 1 | Host strobe, active low, asynchronous |
| req | input | 1 | Consumer request for the next byte, one-cycle pulse |
| ack_n | output | 1 | Acknowledge pulse to the host, active low |
| busy | output | 1 | High when the receiver cannot accept a byte |
| rx_data | output | DATA_W | Last byte received |
| rx_valid | output | 1 | One-cycle pulse when rx_data holds a new byte |
| ovr_count | output | OVR_W | Saturating count of strobes seen while busy |

## Verification
The transfer path is driven with several byte values: alternating bits, all zeros and all ones. This shows that each data line is latched on its own and that an all-zero byte is still flagged by rx_valid. Strobes are also sent while idle, during the acknowledge pulse and in the waiting phase. This separates the three ways an edge can be handled: counted, dropped silently, or captured. Requests repeated inside a transfer show whether the acknowledge timer restarts or a second byte is taken. A reset after a real byte shows whether stale data is cleared.

// File: rtl/lpt_rx_pkg.sv
package lpt_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_WAIT = 2'd2
    } rx_state_e;
endpackage

// File: rtl/lpt_strobe_sync.sv
// Synchronizes the asynchronous strobe, detects its falling edge and
// delays the data lines by the same depth so both stay aligned.
module lpt_strobe_sync #(
    parameter int DATA_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic [DATA_W-1:0] data_in,
    output logic              fall,
    output logic [DATA_W-1:0] data_out
);
    // sync_q[STAGES-1] is the synchronized strobe, sync_q[STAGES] its history
    logic [STAGES:0]   sync_d, sync_q;
    logic [DATA_W-1:0] pipe_d [STAGES];
    logic [DATA_W-1:0] pipe_q [STAGES];

    always_comb begin
        sync_d = {sync_q[STAGES-1:0], strobe_n};
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_pipe
            if (g == 0) begin : g_first
                always_comb pipe_d[g] = data_in;
            end else begin : g_rest
                always_comb pipe_d[g] = pipe_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
        end else begin
            sync_q <= sync_d;
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= pipe_d[i];
        end
    end

    assign fall     = sync_q[STAGES] & ~sync_q[STAGES-1];
    assign data_out = pipe_q[STAGES-1];
endmodule

// File: rtl/lpt_pulse_timer.sv
// Down-counter that times the acknowledge pulse; done is high on the
// last cycle of a CYCLES-long window started by load.
module lpt_pulse_timer #(
    parameter int CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = CNT_W'(CYCLES - 1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/lpt_sat_counter.sv
// Saturating event counter.
module lpt_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != '1)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/lpt_receiver.sv
module lpt_receiver
    import lpt_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ACK_CYCLES  = 500,
    parameter int SYNC_STAGES = 2,
    parameter int OVR_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] host_data,
    input  logic              host_strobe_n,
    input  logic              req,
    output logic              ack_n,
    output logic              busy,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic [OVR_W-1:0]  ovr_count
);
    typedef struct packed {
        rx_state_e         state;
        logic [DATA_W-1:0] data;
        logic              valid;
    } rx_regs_t;

    rx_regs_t          r_d, r_q;
    logic              strobe_fall;
    logic [DATA_W-1:0] cap_data;
    logic              timer_load;
    logic              timer_done;
    logic              ovr_inc;

    lpt_strobe_sync #(
        .DATA_W (DATA_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (host_strobe_n),
        .data_in  (host_data),
        .fall     (strobe_fall),
        .data_out (cap_data)
    );

    lpt_pulse_timer #(
        .CYCLES (ACK_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .done  (timer_done)
    );

    lpt_sat_counter #(
        .W (OVR_W)
    ) u_ovr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ovr_inc),
        .count (ovr_count)
    );

    always_comb begin
        r_d        = r_q;
        r_d.valid  = 1'b0;
        timer_load = 1'b0;
        ovr_inc    = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                // strobes here arrive while busy is high: count, never capture
                ovr_inc = strobe_fall;
                if (req) begin
                    r_d.state  = ST_ACK;
                    timer_load = 1'b1;
                end
            end
            ST_ACK: begin
                // req and strobe edges are dropped during the pulse
                if (timer_done) r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (strobe_fall) begin
                    r_d.data  = cap_data;
                    r_d.valid = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, data: '0, valid: 1'b0};
        else        r_q <= r_d;
    end

    assign busy     = (r_q.state == ST_IDLE);
    assign ack_n    = (r_q.state != ST_ACK);
    assign rx_data  = r_q.data;
    assign rx_valid = r_q.valid;
endmodule

// File: rtl/lpt_receiver_chk.sv
module lpt_receiver_chk #(
    parameter int ACK_CYCLES = 500,
    parameter int OVR_W      = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_n,
    input logic             busy,
    input logic             rx_valid,
    input logic [OVR_W-1:0] ovr_count
);
    int unsigned ack_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ack_run_q <= 0;
        else if (ack_n) ack_run_q <= 0;
        else            ack_run_q <= ack_run_q + 1;
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (busy && ack_n && !rx_valid && (ovr_count == '0)));

    p_ack_busy_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> !busy);

    p_ack_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_n) |-> (ack_run_q == ACK_CYCLES));

    p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_busy_rise_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> rx_valid);

    p_valid_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (busy && ack_n));

    p_ovr_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ovr_count >= $past(ovr_count)));
endmodule

bind lpt_receiver lpt_receiver_chk #(
    .ACK_CYCLES (ACK_CYCLES),
    .OVR_W      (OVR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_n     (ack_n),
    .busy      (busy),
    .rx_valid  (rx_valid),
    .ovr_count (ovr_count)
);

// File: tb/lpt_receiver_tb_top.sv
module lpt_receiver_tb_top;
    localparam int DATA_W = 8;
    localparam int ACKC   = 8;
    localparam int OVR_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] host_data = '0;
    logic              host_strobe_n = 1'b1;
    logic              req = 1'b0;
    logic              ack_n, busy, rx_valid;
    logic [DATA_W-1:0] rx_data;
    logic [OVR_W-1:0]  ovr_count;

    int errors = 0;
    int checks = 0;
    int vcount = 0;
    int vdata  = 0;
    int ack_run = 0;
    int ack_last = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lpt_receiver #(
        .DATA_W      (DATA_W),
        .ACK_CYCLES  (ACKC),
        .SYNC_STAGES (2),
        .OVR_W       (OVR_W)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_data     (host_data),
        .host_strobe_n (host_strobe_n),
        .req           (req),
        .ack_n         (ack_n),
        .busy          (busy),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .ovr_count     (ovr_count)
    );

    // observer of the port behaviour
    always @(posedge clk) begin
        if (rx_valid) begin
            vcount <= vcount + 1;
            vdata  <= int'(rx_data);
        end
        if (!ack_n) ack_run <= ack_run + 1;
        else begin
            if (ack_run != 0) ack_last <= ack_run;
            ack_run <= 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
    endtask

    task automatic send_byte(input logic [DATA_W-1:0] d);
        @(negedge clk) host_data = d;
        cycles(2);
        host_strobe_n = 1'b0;
        cycles(4);
        host_strobe_n = 1'b1;
        cycles(4);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        chk(busy == 1'b1, "R1 busy", int'(busy), 1);
        chk(ack_n == 1'b1, "R1 ack_n", int'(ack_n), 1);
        chk(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
        chk(ovr_count == '0, "R1 ovr_count", int'(ovr_count), 0);
        chk(rx_data == '0, "R1 rx_data", int'(rx_data), 0);
    endtask

    task automatic t_transfer(input logic [DATA_W-1:0] d);
        int v0;
        v0 = vcount;
        pulse_req();
        chk(busy == 1'b0, "R2 busy low", int'(busy), 0);
        chk(ack_n == 1'b0, "R2 ack low", int'(ack_n), 0);
        cycles(ACKC + 2);
        chk(ack_n == 1'b1, "R3 ack released", int'(ack_n), 1);
        chk(busy == 1'b0, "R3 busy held low", int'(busy), 0);
        chk(ack_last == ACKC, "R3 ack width", ack_last, ACKC);
        send_byte(d);
        chk(vcount == v0 + 1, "R4 one valid", vcount - v0, 1);
        chk(vdata == int'(d), "R4 data", vdata, int'(d));
        chk(busy == 1'b1, "R5 busy high", int'(busy), 1);
        cycles(ACKC + 4);
        chk(busy == 1'b1 && ack_n == 1'b1, "R5 stays idle", int'(busy), 1);
    endtask

    task automatic t_overrun();
        int v0;
        int d0;
        v0 = vcount;
        d0 = int'(rx_data);
        send_byte(8'h5A);
        chk(vcount == v0, "R6 no valid", vcount - v0, 0);
        chk(int'(rx_data) == d0, "R6 data kept", int'(rx_data), d0);
        chk(ovr_count == 2'd1, "R6 counted", int'(ovr_count), 1);
        for (int i = 0; i < 4; i++) send_byte(8'h11);
        chk(ovr_count == 2'd3, "R7 saturated", int'(ovr_count), 3);
        chk(int'(rx_data) == d0, "R6 data kept after burst", int'(rx_data), d0);
    endtask

    task automatic t_req_in_transfer();
        int v0;
        v0 = vcount;
        pulse_req();
        cycles(2);
        pulse_req();
        cycles(ACKC + 2);
        chk(ack_last == ACKC, "R8 ack not restarted", ack_last, ACKC);
        chk(busy == 1'b0 && ack_n == 1'b1, "R8 waiting", int'(ack_n), 1);
        pulse_req();
        cycles(2);
        chk(ack_n == 1'b1, "R8 no ack in wait", int'(ack_n), 1);
        send_byte(8'h3C);
        chk(vcount == v0 + 1, "R8 single byte", vcount - v0, 1);
        chk(vdata == 8'h3C, "R8 data", vdata, 8'h3C);
        cycles(ACKC + 4);
        chk(busy == 1'b1 && ack_n == 1'b1, "R8 no extra transfer", int'(busy), 1);
    endtask

    task automatic t_strobe_in_ack();
        int v0;
        int o0;
        v0 = vcount;
        o0 = int'(ovr_count);
        host_data = 8'hC3;
        pulse_req();
        host_strobe_n = 1'b0;
        cycles(2);
        host_strobe_n = 1'b1;
        cycles(ACKC + 2);
        chk(vcount == v0, "R9 no capture in ack", vcount - v0, 0);
        chk(int'(ovr_count) == o0, "R9 not counted", int'(ovr_count), o0);
        chk(busy == 1'b0 && ack_n == 1'b1, "R9 still waiting", int'(busy), 0);
        send_byte(8'h96);
        chk(vcount == v0 + 1, "R9 later edge captured", vcount - v0, 1);
        chk(vdata == 8'h96, "R9 data", vdata, 8'h96);
    endtask

    initial begin
        t_reset();
        t_transfer(8'hA5);
        t_transfer(8'h00);
        t_transfer(8'hFF);
        t_overrun();
        t_req_in_transfer();
        t_reset();   // clears counter and rx_data after real traffic (R1)
        t_strobe_in_ack();
        t_transfer(8'h81);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule